// File: doc/BRIEF.md
# Four-Lane Alignment-Column Deskewer

This block sits after four independent byte-wide receive lanes. Each lane has already been word-aligned and 8b/10b-decoded, so each arrives as a data byte, a control flag and a synchronization flag from its word aligner. Wires, serializers and recovered clocks give each lane its own latency. The block removes the lane-to-lane offset so that the four lanes leave it as coherent columns.

The transmitter inserts Align code groups into the idle stream, and these serve as the marker. Nothing happens until all four lanes report synchronization. The block then waits for the first Align on any lane and opens a measurement window. It records how many cycles later each of the other lanes shows its Align. If all four arrive inside the window, the earlier lanes get extra delay from a per-lane tap into a short shift register. The result is then checked against the Align columns that follow. Lock is declared only after several clean columns in a row. Once locked, the block counts columns in which only some lanes show Align, and drops lock after a set number of them. Losing synchronization on any lane drops everything at once.

Top module: `lane_deskew4`

## Requirements
- R1: A lane carries an Align when its control flag is 1 and its data byte equals ALIGN_CODE (default 8'h7C). The same byte with the control flag at 0 is ordinary data and never starts or completes a measurement.
- R2: While any bit of `lane_sync` is 0, `deskew_done` is 0, every output byte and control flag is 0, and no measurement starts.
- R3: Each output lane is its input lane delayed by tap+1 clock cycles. All taps are 0 after reset and after a synchronization loss.
- R4: The first Align on any lane opens a window. Each lane's first Align is recorded with its offset 0..DEPTH-1 from that cycle, and later Aligns on an already recorded lane are ignored. Once all four lanes are recorded, each tap is loaded with (largest offset - own offset), so those Aligns leave in one output column.
- R5: If a lane is still unrecorded in the cycle of offset DEPTH-1, the window closes without changing the taps, and the search restarts in the following cycle.
- R6: After a measurement, `deskew_done` rises in the cycle after the LOCK_COLS-th consecutive output column in which all four lanes show Align. An output column with Align on some lanes but not all, seen before that point, restarts the search.
- R7: While locked, an output column with Align on some lanes but not all counts one error, and a column with Align on all lanes clears the count. When the count reaches ERR_LIMIT, `deskew_done` falls in the next cycle and the search restarts with the taps kept until a new measurement completes.
- R8: When any `lane_sync` bit falls, from the next clock edge `deskew_done` is 0, the delay lines and taps are cleared, and the search starts over.
- R9: With `rst_n` low at a clock edge, the block leaves that edge with `deskew_done` 0 and all outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock shared by the four lanes |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sync | input | 4 | Per-lane synchronization flag from the word aligners |
| in_ctrl | input | 4 | Per-lane control flag of the incoming code group |
| in_data | input | 4*LANE_W | Incoming bytes, lane n at bits [n*LANE_W +: LANE_W] |
| out_ctrl | output | 4 | Control flags of the realigned lanes |
| out_data | output | 4*LANE_W | Realigned bytes, same packing as in_data |
| deskew_done | output | 1 | High while the four lanes are locked into common columns |

## Verification
The bench targets the window edge: a skew equal to DEPTH-1 must lock, and a spread one Align period cannot cover inside the window must never lock. A design off by one in its window count gets one of these wrong. It drops one lane's Align once, and later four times. A design that never clears its error count, or that counts from the wrong threshold, loses lock too early or holds it too long. It also sends the Align byte with the control flag at 0, drops a single lane's sync for one cycle, and holds a lane unsynchronized while Aligns flow. A design that decodes only the data byte, keeps stale delay-line contents, or starts measuring too early then shows a spurious lock or non-zero output.

// File: rtl/ldsk_pkg.sv
// Shared definitions for the four-lane deskewer.
// Assumes exactly four lanes; the lane count is fixed by the link format.
package ldsk_pkg;

    localparam int NUM_LANES = 4;

    // Search progress: waiting for a first marker, measuring, or holding taps
    typedef enum logic [1:0] {
        SRCH_SEEK   = 2'd0,
        SRCH_WINDOW = 2'd1,
        SRCH_HOLD   = 2'd2
    } srch_state_e;

    // Lock monitor progress: confirming a fresh measurement, or locked
    typedef enum logic {
        MON_VERIFY = 1'b0,
        MON_LOCKED = 1'b1
    } mon_state_e;

endpackage

// File: rtl/ldsk_lane_delay.sv
// One lane's elastic delay line.
// Shifts one code group per clock into DEPTH registers and presents the
// register picked by 'tap'; latency is tap+1 cycles. 'clear' empties the line.
// Assumes tap < DEPTH; an out-of-range tap yields zero.
module ldsk_lane_delay #(
    parameter int W     = 9,
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [W-1:0]  din,
    input  logic [TW-1:0] tap,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [DEPTH];

    // Shift register, emptied on reset or synchronization loss
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
        end
    end

    // Output tap selection
    always_comb begin
        dout = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (tap == TW'(k)) dout = stage[k];
        end
    end

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (dout == '0));

endmodule

// File: rtl/ldsk_skew_search.sv
// Skew measurement for four lanes.
// Watches the input-side marker flags. The first marker on any lane opens a
// window of DEPTH cycles (offsets 0..DEPTH-1); each lane's first marker
// offset is recorded. When all four are recorded the taps are loaded so the
// markers meet in one column, and the block holds until 'restart'.
// Assumes DEPTH >= 2 and that 'clear' is high whenever any lane is unsynced.
module ldsk_skew_search
    import ldsk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic [NUM_LANES-1:0]      lane_align,
    input  logic                      restart,
    output logic [NUM_LANES*TW-1:0]   taps_o,
    output logic                      hold_o
);

    localparam logic [TW-1:0] MAX_SKEW = TW'(DEPTH - 1);

    srch_state_e          state;
    logic [NUM_LANES-1:0] seen;
    logic [NUM_LANES-1:0] seen_base;
    logic [NUM_LANES-1:0] fresh;
    logic [NUM_LANES-1:0] seen_nx;
    logic [TW-1:0]        cnt;
    logic [TW-1:0]        cur_off;
    logic [TW-1:0]        off_q   [NUM_LANES];
    logic [TW-1:0]        tap_new [NUM_LANES];
    logic                 complete;
    logic                 any_zero_tap;

    // Which lanes are newly seen this cycle, and the taps they would imply
    always_comb begin
        seen_base = (state == SRCH_WINDOW) ? seen : '0;
        fresh     = lane_align & ~seen_base;
        seen_nx   = seen_base | lane_align;
        cur_off   = (state == SRCH_WINDOW) ? cnt : '0;
        complete  = (state != SRCH_HOLD) && (&seen_nx);
        for (int l = 0; l < NUM_LANES; l++) begin
            tap_new[l] = fresh[l] ? '0 : (cur_off - off_q[l]);
        end
    end

    // Search state machine with offset recording and tap loading
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state  <= SRCH_SEEK;
            seen   <= '0;
            cnt    <= '0;
            taps_o <= '0;
            for (int l = 0; l < NUM_LANES; l++) off_q[l] <= '0;
        end else begin
            case (state)
                SRCH_SEEK: begin
                    if (|lane_align) begin
                        if (complete) begin
                            for (int l = 0; l < NUM_LANES; l++)
                                taps_o[l*TW +: TW] <= tap_new[l];
                            state <= SRCH_HOLD;
                        end else begin
                            seen <= lane_align;
                            for (int l = 0; l < NUM_LANES; l++) off_q[l] <= '0;
                            cnt   <= TW'(1);
                            state <= SRCH_WINDOW;
                        end
                    end
                end
                SRCH_WINDOW: begin
                    if (complete) begin
                        for (int l = 0; l < NUM_LANES; l++)
                            taps_o[l*TW +: TW] <= tap_new[l];
                        state <= SRCH_HOLD;
                    end else if (cnt == MAX_SKEW) begin
                        seen  <= '0;
                        state <= SRCH_SEEK;
                    end else begin
                        seen <= seen_nx;
                        for (int l = 0; l < NUM_LANES; l++)
                            if (fresh[l]) off_q[l] <= cnt;
                        cnt <= cnt + TW'(1);
                    end
                end
                SRCH_HOLD: begin
                    if (restart) begin
                        seen  <= '0;
                        state <= SRCH_SEEK;
                    end
                end
                default: state <= SRCH_SEEK;
            endcase
        end
    end

    assign hold_o = (state == SRCH_HOLD);

    // Detects that at least one lane got no extra delay
    always_comb begin
        any_zero_tap = 1'b0;
        for (int l = 0; l < NUM_LANES; l++)
            if (taps_o[l*TW +: TW] == '0) any_zero_tap = 1'b1;
    end

    // R4
    latest_lane_untapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> any_zero_tap);

    // R5
    window_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRCH_WINDOW && cnt == MAX_SKEW) |=> (state != SRCH_WINDOW));

endmodule

// File: rtl/ldsk_lock_monitor.sv
// Lock qualification on the realigned output columns.
// Active only while the search holds a measurement. Needs LOCK_COLS full
// marker columns in a row to lock; a partial column before that asks for a
// new search. When locked, partial columns count errors, full ones clear
// the count, and ERR_LIMIT errors drop the lock and ask for a new search.
// Assumes 'active' falls at the same edge at which 'restart_o' is honoured.
module ldsk_lock_monitor
    import ldsk_pkg::*;
#(
    parameter int LOCK_COLS = 4,
    parameter int ERR_LIMIT = 4,
    parameter int GW        = $clog2(LOCK_COLS + 1),
    parameter int EW        = $clog2(ERR_LIMIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 active,
    input  logic [NUM_LANES-1:0] col_align,
    output logic                 restart_o,
    output logic                 done_o
);

    mon_state_e     st;
    logic [GW-1:0]  good_cnt;
    logic [EW-1:0]  err_cnt;
    logic           any_mark;
    logic           full_col;
    logic           partial;

    // Column classification and restart request
    always_comb begin
        any_mark  = |col_align;
        full_col  = &col_align;
        partial   = any_mark && !full_col;
        restart_o = active && partial &&
                    ((st == MON_VERIFY) || (err_cnt == EW'(ERR_LIMIT - 1)));
    end

    // Verify / locked state machine with good and error counters
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !active) begin
            st       <= MON_VERIFY;
            good_cnt <= '0;
            err_cnt  <= '0;
        end else begin
            case (st)
                MON_VERIFY: begin
                    if (partial) begin
                        good_cnt <= '0;
                    end else if (full_col) begin
                        if (good_cnt == GW'(LOCK_COLS - 1)) begin
                            good_cnt <= '0;
                            st       <= MON_LOCKED;
                        end else begin
                            good_cnt <= good_cnt + GW'(1);
                        end
                    end
                end
                MON_LOCKED: begin
                    if (full_col) begin
                        err_cnt <= '0;
                    end else if (partial) begin
                        if (err_cnt == EW'(ERR_LIMIT - 1)) begin
                            err_cnt <= '0;
                            st      <= MON_VERIFY;
                        end else begin
                            err_cnt <= err_cnt + EW'(1);
                        end
                    end
                end
                default: st <= MON_VERIFY;
            endcase
        end
    end

    assign done_o = (st == MON_LOCKED);

    // R6
    lock_after_full_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(full_col));

    // R7
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> ($past(partial) || $past(clear)));

endmodule

// File: rtl/lane_deskew4.sv
// Four-lane deskewer: top level.
// Decodes the marker on every input lane, measures lane skew, delays the
// early lanes in per-lane delay lines and qualifies lock on output columns.
// Assumes the inputs of all lanes are in this clock domain and already
// word-aligned and decoded; any unsynced lane holds the block cleared.
module lane_deskew4
    import ldsk_pkg::*;
#(
    parameter int              LANE_W     = 8,
    parameter int              DEPTH      = 8,
    parameter int              LOCK_COLS  = 4,
    parameter int              ERR_LIMIT  = 4,
    parameter logic [LANE_W-1:0] ALIGN_CODE = LANE_W'(8'h7C)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES-1:0]          lane_sync,
    input  logic [NUM_LANES-1:0]          in_ctrl,
    input  logic [NUM_LANES*LANE_W-1:0]   in_data,
    output logic [NUM_LANES-1:0]          out_ctrl,
    output logic [NUM_LANES*LANE_W-1:0]   out_data,
    output logic                          deskew_done
);

    localparam int TW = $clog2(DEPTH);
    localparam int GW = LANE_W + 1;

    logic                        all_sync;
    logic                        clear;
    logic [NUM_LANES-1:0]        in_align;
    logic [NUM_LANES-1:0]        out_align;
    logic [NUM_LANES*TW-1:0]     taps;
    logic                        hold;
    logic                        restart;

    assign all_sync = &lane_sync;
    assign clear    = !all_sync;

    // Per-lane marker decode and delay line
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [GW-1:0] dly_out;

        assign in_align[l] = in_ctrl[l] && (in_data[l*LANE_W +: LANE_W] == ALIGN_CODE);

        ldsk_lane_delay #(
            .W     (GW),
            .DEPTH (DEPTH),
            .TW    (TW)
        ) u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .din   ({in_ctrl[l], in_data[l*LANE_W +: LANE_W]}),
            .tap   (taps[l*TW +: TW]),
            .dout  (dly_out)
        );

        assign out_ctrl[l]                   = dly_out[GW-1];
        assign out_data[l*LANE_W +: LANE_W]  = dly_out[LANE_W-1:0];
        assign out_align[l] = dly_out[GW-1] && (dly_out[LANE_W-1:0] == ALIGN_CODE);
    end

    ldsk_skew_search #(
        .DEPTH (DEPTH),
        .TW    (TW)
    ) u_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .lane_align (in_align),
        .restart    (restart),
        .taps_o     (taps),
        .hold_o     (hold)
    );

    ldsk_lock_monitor #(
        .LOCK_COLS (LOCK_COLS),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .active    (hold),
        .col_align (out_align),
        .restart_o (restart),
        .done_o    (deskew_done)
    );

    // R8
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_sync |=> !deskew_done);

    // R2
    unsynced_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !all_sync |=> (out_ctrl == '0 && out_data == '0));

    // R6
    done_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_done |-> hold);

endmodule

// File: tb/lane_deskew4_tb.sv
module lane_deskew4_tb;

    localparam int DEPTH = 8;
    localparam int LOCKN = 4;
    localparam int ERRN  = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  lane_sync;
    logic [3:0]  in_ctrl;
    logic [31:0] in_data;
    logic [3:0]  out_ctrl;
    logic [31:0] out_data;
    logic        deskew_done;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    lane_deskew4 u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_sync   (lane_sync),
        .in_ctrl     (in_ctrl),
        .in_data     (in_data),
        .out_ctrl    (out_ctrl),
        .out_data    (out_data),
        .deskew_done (deskew_done)
    );

    // ---------------- reference model ----------------
    int         ms;          // 0 seek, 1 window, 2 verify, 3 locked
    int         mcnt, mgood, merr;
    bit         mseen [4];
    int         moff  [4];
    int         mtap  [4];
    logic [8:0] mh    [4][DEPTH];
    logic [8:0] mout  [4];
    bit         mdone;

    function automatic bit is_al(logic [8:0] v);
        return v[8] && v[7:0] == 8'h7C;
    endfunction

    initial begin
        ms = 0; mcnt = 0; mgood = 0; merr = 0; mdone = 0;
        for (int l = 0; l < 4; l++) begin
            mseen[l] = 0; moff[l] = 0; mtap[l] = 0; mout[l] = '0;
            for (int k = 0; k < DEPTH; k++) mh[l][k] = '0;
        end
    end

    always @(posedge clk) begin
        bit ia [4];
        bit anyo, allo, anyi, alls, restart;
        anyo = 0; allo = 1; anyi = 0;
        for (int l = 0; l < 4; l++) begin
            ia[l] = is_al({in_ctrl[l], in_data[l*8 +: 8]});
            anyi  = anyi | ia[l];
            anyo  = anyo | is_al(mout[l]);
            allo  = allo & is_al(mout[l]);
        end
        if (!rst_n || lane_sync != 4'hF) begin
            ms = 0; mcnt = 0; mgood = 0; merr = 0;
            for (int l = 0; l < 4; l++) begin
                mseen[l] = 0; moff[l] = 0; mtap[l] = 0;
                for (int k = 0; k < DEPTH; k++) mh[l][k] = '0;
            end
        end else begin
            restart = 0;
            if (ms == 2) begin
                if (allo) begin
                    mgood++;
                    if (mgood == LOCKN) begin ms = 3; mgood = 0; end
                end else if (anyo) restart = 1;
            end else if (ms == 3) begin
                if (allo) merr = 0;
                else if (anyo) begin
                    merr++;
                    if (merr == ERRN) restart = 1;
                end
            end
            if (restart) begin
                ms = 0; mgood = 0; merr = 0;
            end else if (ms == 0 && anyi) begin
                alls = 1;
                for (int l = 0; l < 4; l++) begin
                    mseen[l] = ia[l]; moff[l] = 0; alls = alls & ia[l];
                end
                if (alls) begin
                    for (int l = 0; l < 4; l++) mtap[l] = 0;
                    ms = 2; mgood = 0; merr = 0;
                end else begin
                    ms = 1; mcnt = 1;
                end
            end else if (ms == 1) begin
                alls = 1;
                for (int l = 0; l < 4; l++) begin
                    if (ia[l] && !mseen[l]) begin mseen[l] = 1; moff[l] = mcnt; end
                    alls = alls & mseen[l];
                end
                if (alls) begin
                    for (int l = 0; l < 4; l++) mtap[l] = mcnt - moff[l];
                    ms = 2; mgood = 0; merr = 0;
                end else if (mcnt == DEPTH - 1) ms = 0;
                else mcnt++;
            end
            for (int l = 0; l < 4; l++) begin
                for (int k = DEPTH - 1; k > 0; k--) mh[l][k] = mh[l][k-1];
                mh[l][0] = {in_ctrl[l], in_data[l*8 +: 8]};
            end
        end
        for (int l = 0; l < 4; l++) mout[l] = mh[l][mtap[l]];
        mdone = (ms == 3);
    end

    // ---------------- stimulus ----------------
    int         n = 0;
    int         period = 16;
    bit         marks_on = 0;
    bit         fake = 0;
    int         skew [4];
    bit         kill [4];
    bit         chk_pass = 0;
    logic [8:0] bh [16];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int l = 0; l < 4; l++)
            chk({out_ctrl[l], out_data[l*8 +: 8]} == mout[l], "R3 R4", "lane output vs model",
                {out_ctrl[l], out_data[l*8 +: 8]}, mout[l]);
        chk(deskew_done == mdone, "R6 R7", "done vs model", deskew_done, mdone);
        if (chk_pass)
            chk(out_ctrl == in_ctrl && out_data == in_data, "R3", "zero-tap latency",
                out_data, in_data);
    endtask

    task automatic step();
        logic [8:0] v;
        @(negedge clk);
        compare_all();
        n++;
        for (int k = 15; k > 0; k--) bh[k] = bh[k-1];
        if (n % period == 0 && fake)          bh[0] = {1'b0, 8'h7C};
        else if (n % period == 0 && marks_on) bh[0] = {1'b1, 8'h7C};
        else                                  bh[0] = {1'b0, 8'((n * 29 + 5) & 8'hFF)};
        for (int l = 0; l < 4; l++) begin
            v = bh[skew[l]];
            if (kill[l] && is_al(v)) v = {1'b0, 8'hBC};
            in_ctrl[l]       = v[8];
            in_data[l*8 +: 8] = v[7:0];
        end
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    task automatic set_skew(int a, int b, int c, int d);
        skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        bit anyo, allo;
        rst_n = 0; lane_sync = 4'h0; in_ctrl = '0; in_data = '0;
        for (int k = 0; k < 16; k++) bh[k] = '0;
        for (int l = 0; l < 4; l++) kill[l] = 0;
        set_skew(0, 3, 1, 5);
        run(3);
        // R9: reset state
        chk(deskew_done == 0 && out_ctrl == 0 && out_data == 0, "R9", "reset outputs",
            out_data, 0);
        rst_n = 1;

        // R2: one lane unsynced while markers flow
        lane_sync = 4'b1011; marks_on = 1;
        run(60);
        chk(deskew_done == 0, "R2", "done while unsynced", deskew_done, 0);
        chk(out_ctrl == 0 && out_data == 0, "R2", "outputs while unsynced", out_data, 0);

        // R1 and R3: marker byte without control flag, zero taps
        lane_sync = 4'hF; marks_on = 0; fake = 1; set_skew(0, 0, 0, 0);
        run(2);
        chk_pass = 1;
        run(40);
        chk_pass = 0;
        chk(deskew_done == 0, "R1", "no lock on data-flagged marker byte", deskew_done, 0);

        // R4 and R6: real markers with skew 0,3,1,5
        fake = 0; marks_on = 1; set_skew(0, 3, 1, 5);
        run(120);
        chk(deskew_done == 1, "R6", "lock reached", deskew_done, 1);
        for (int i = 0; i < 32; i++) begin
            step();
            anyo = 0; allo = 1;
            for (int l = 0; l < 4; l++) begin
                anyo = anyo | (out_ctrl[l] && out_data[l*8 +: 8] == 8'h7C);
                allo = allo & (out_ctrl[l] && out_data[l*8 +: 8] == 8'h7C);
            end
            if (anyo) chk(allo, "R4", "marker column aligned", out_ctrl, 4'hF);
        end

        // R7: one error, then a good column clears the count
        kill[2] = 1; run(16); kill[2] = 0;
        run(40);
        chk(deskew_done == 1, "R7", "single error keeps lock", deskew_done, 1);
        kill[2] = 1; run(84);
        chk(deskew_done == 0, "R7", "error limit drops lock", deskew_done, 0);
        kill[2] = 0;
        run(120);
        chk(deskew_done == 1, "R7", "relock after errors", deskew_done, 1);

        // R8: single-cycle sync loss on lane 1
        lane_sync = 4'b1101;
        step();
        chk(deskew_done == 0, "R8", "done after sync loss", deskew_done, 0);
        chk(out_ctrl == 0 && out_data == 0, "R8", "lines cleared", out_data, 0);
        lane_sync = 4'hF;
        run(120);
        chk(deskew_done == 1, "R8", "relock after sync return", deskew_done, 1);

        // R5: spread beyond the window never locks
        set_skew(0, 9, 2, 4);
        run(200);
        chk(deskew_done == 0, "R5", "no lock beyond window", deskew_done, 0);

        // R4 boundary: skew of DEPTH-1 locks
        set_skew(0, 7, 2, 4);
        run(150);
        chk(deskew_done == 1, "R4", "lock at maximum skew", deskew_done, 1);

        run(2);
        summary();
        $finish;
    end

endmodule